// File: doc/BRIEF.md
# Vertical-Blank Pacer with Frame-Skip Swap Gating

This block paces a display pipeline. A free-running cycle counter raises a vertical-blank event once every programmed number of clock cycles. The programmed number is normally the core clock rate divided by the refresh rate. On each event the block advances a frame counter and decides whether the new frame is skipped. It also decides whether the front and back buffers should be exchanged, and it raises one interrupt pulse for each of the two screens.

When an event is serviced late, the caller reports the lateness in cycles on a dedicated input. The interval that follows is shortened by that amount, so the long-run event rate does not drift.

A frame counts as skipped when the frame counter shares any set bit with the frame-skip setting. A swap is not issued on every event. It is gated by a rule that looks at the skip setting and at the skip states of the previous and current frames. The effect is that buffers are only exchanged after a frame was actually rendered.

Top module: `vbs_ctrl`

## Requirements
- R1: While reset is asserted, all pulse outputs and the skip flag are 0. Reset clears the frame counter and both skip states. The first vertical-blank pulse appears exactly L clock edges after reset is released, where L is the programmed period (a period of 0 acts as 1).
- R2: With a lateness input of 0, successive vertical-blank pulses are exactly `period_i` cycles apart (a period of 0 acts as 1).
- R3: The lateness value present at the edge of an event shortens the following interval to `period_i - late_i`. The interval never falls below 1 cycle.
- R4: Every event produces one-cycle pulses on both `vblank_irq_top_o` and `vblank_irq_bot_o` in the same cycle. Neither pulse appears at any other time.
- R5: On an event the frame counter (FW bits, wrapping) increments. The skip flag then becomes 1 exactly when the new count ANDed with `frame_skip_i` is nonzero. Between events the skip flag holds its value.
- R6: With a frame-skip setting of 0, every event issues a swap pulse.
- R7: With a nonzero setting, an event issues a swap only when the skip flag differs from its value before the event, and when ((setting != 1) XOR previous skip flag) is 1.
- R8: A swap pulse is one cycle wide and only appears in a cycle that also carries the vertical-blank pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | PW | Cycles between vertical-blank events |
| late_i | input | PW | Service lateness of the current event, in cycles |
| frame_skip_i | input | FW | Frame-skip setting |
| vblank_irq_top_o | output | 1 | Vertical-blank interrupt pulse, first screen |
| vblank_irq_bot_o | output | 1 | Vertical-blank interrupt pulse, second screen |
| swap_o | output | 1 | Buffer-swap pulse |
| skip_frame_o | output | 1 | The current frame is skipped |

## Verification
All four outputs change on the same clock edge: the edge that closes an interval, which is L edges after reset release or after the previous event. A single register stage sits between the internal tick and the pulses, and the skip flag is registered on that same edge. The bench keeps a countdown model that it steps once per edge and compares against the outputs at the following falling edge, so a result is due in the same half-cycle the model predicts it. The lateness input and the settings are changed only at falling edges, after the model has consumed the values that the design sampled.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  // Length of the next interval: a period of 0 acts as 1, lateness shortens
  // the interval but never below one cycle.
  function automatic logic [31:0] interval_len(input logic [31:0] per,
                                               input logic [31:0] late);
    logic [31:0] p;
    p = (per == 32'd0) ? 32'd1 : per;
    if (late >= p) return 32'd1;
    return p - late;
  endfunction

  // Swap gating: always with setting 0, otherwise on a change of skip state
  // qualified by (setting != 1) xor previous skip state.
  function automatic logic swap_rule(input logic set_zero,
                                     input logic set_one,
                                     input logic prev_skip,
                                     input logic cur_skip);
    if (set_zero) return 1'b1;
    return (prev_skip != cur_skip) && ((!set_one) ^ prev_skip);
  endfunction

endpackage

// File: rtl/vbs_period_timer.sv
module vbs_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] late_i,
  output logic          tick_o
);
  import vbs_pkg::*;

  logic [PW-1:0] elapsed_q;
  logic [PW-1:0] next_len_q;
  logic          first_q;
  logic [PW-1:0] limit;
  logic [PW-1:0] adj_len;

  always_comb begin
    limit   = first_q ? PW'(interval_len(32'(period_i), 32'd0)) : next_len_q;
    adj_len = PW'(interval_len(32'(period_i), 32'(late_i)));
    tick_o  = (elapsed_q == limit - PW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q  <= '0;
      next_len_q <= PW'(1);
      first_q    <= 1'b1;
    end else if (tick_o) begin
      elapsed_q  <= '0;
      next_len_q <= adj_len;
      first_q    <= 1'b0;
    end else begin
      elapsed_q  <= elapsed_q + PW'(1);
    end
  end

  AST_ELAPSED_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed_q < limit); // R2

  AST_NEXT_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    next_len_q != '0); // R3

endmodule

// File: rtl/vbs_frame_tracker.sv
module vbs_frame_tracker #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [FW-1:0] setting_i,
  output logic          skip_o,
  output logic          swap_now_o
);
  import vbs_pkg::*;

  logic [FW-1:0] frame_q;
  logic          cur_q;
  logic          prev_q;
  logic [FW-1:0] frame_nx;
  logic          cur_nx;

  always_comb begin
    frame_nx   = frame_q + FW'(1);
    cur_nx     = |(frame_nx & setting_i);
    swap_now_o = tick_i && swap_rule(setting_i == '0, setting_i == FW'(1), cur_q, cur_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      cur_q   <= 1'b0;
      prev_q  <= 1'b0;
    end else if (tick_i) begin
      frame_q <= frame_nx;
      prev_q  <= cur_q;
      cur_q   <= cur_nx;
    end
  end

  assign skip_o = cur_q;

  AST_SKIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cur_q)); // R5

  AST_ZERO_SETTING_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && setting_i == '0) |=> !cur_q); // R5

  AST_PREV_TRACKS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (prev_q == $past(cur_q))); // R7

endmodule

// File: rtl/vbs_ctrl.sv
module vbs_ctrl #(
  parameter int PW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] late_i,
  input  logic [FW-1:0] frame_skip_i,
  output logic          vblank_irq_top_o,
  output logic          vblank_irq_bot_o,
  output logic          swap_o,
  output logic          skip_frame_o
);

  logic tick;
  logic swap_now;

  vbs_period_timer #(.PW(PW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .late_i   (late_i),
    .tick_o   (tick)
  );

  vbs_frame_tracker #(.FW(FW)) u_frames (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .setting_i  (frame_skip_i),
    .skip_o     (skip_frame_o),
    .swap_now_o (swap_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vblank_irq_top_o <= 1'b0;
      vblank_irq_bot_o <= 1'b0;
      swap_o           <= 1'b0;
    end else begin
      vblank_irq_top_o <= tick;
      vblank_irq_bot_o <= tick;
      swap_o           <= swap_now;
    end
  end

  AST_IRQS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq_top_o == vblank_irq_bot_o); // R4

  AST_SWAP_WITH_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> vblank_irq_top_o); // R8

  AST_ZERO_SETTING_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frame_skip_i == '0) |=> swap_o); // R6

  AST_IRQ_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !vblank_irq_top_o); // R4

endmodule

// File: tb/test_vbs_ctrl.sv
module test_vbs_ctrl;
  localparam int PW = 16;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] period_i = PW'(4);
  logic [PW-1:0] late_i = '0;
  logic [FW-1:0] frame_skip_i = '0;
  logic          irq_t, irq_b, swap, skip;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // model state
  int       left;
  int       since_ev;
  int       exp_gap;
  bit       first_ev;
  bit [FW-1:0] m_fc;
  bit       m_cur, m_last, m_swap, m_ev;

  always #4 clk = ~clk;   // 125 MHz

  vbs_ctrl #(.PW(PW), .FW(FW)) i_vbs_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .period_i         (period_i),
    .late_i           (late_i),
    .frame_skip_i     (frame_skip_i),
    .vblank_irq_top_o (irq_t),
    .vblank_irq_bot_o (irq_b),
    .swap_o           (swap),
    .skip_frame_o     (skip)
  );

  function automatic int gap_of(int p, int d);
    if (p == 0) p = 1;
    return (d < p) ? p - d : 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!irq_t && !irq_b && !swap && !skip, "R1 reset outputs",
          {irq_t, irq_b, swap, skip}, 0);
    m_fc = '0; m_cur = 0; m_last = 0;
    left = gap_of(int'(period_i), 0);
    exp_gap = left; since_ev = 0; first_ev = 1;
    rst_n = 1'b1;
  endtask

  // advance one edge, then compare at the falling edge
  task automatic step();
    int d;
    d = int'(late_i);
    @(negedge clk);
    cyc++;
    since_ev++;
    left--;
    m_ev = (left == 0);
    m_swap = 0;
    if (m_ev) begin
      m_fc++;
      m_last = m_cur;
      m_cur  = (m_fc & frame_skip_i) != 0;
      if (frame_skip_i == 0) m_swap = 1;
      else m_swap = (m_cur != m_last) && (((frame_skip_i != 1) ? 1'b1 : 1'b0) != m_last);
      left = gap_of(int'(period_i), d);
    end
    check(irq_t == m_ev, first_ev ? "R1 first vblank" : (exp_gap != int'(period_i) ? "R3 compensated vblank" : "R2 vblank spacing"),
          irq_t, m_ev);
    check(irq_b == irq_t, "R4 irq pair", irq_b, irq_t);
    check(skip == m_cur, "R5 skip flag", skip, m_cur);
    check(swap == m_swap, (frame_skip_i == 0) ? "R6 swap always" : "R7 swap gating", swap, m_swap);
    check(!swap || irq_t, "R8 swap with vblank", swap, irq_t);
    if (m_ev) begin
      check(since_ev == exp_gap, "R3 interval length", since_ev, exp_gap);
      since_ev = 0;
      exp_gap = left;
      first_ev = 0;
    end
  endtask

  initial begin
    // sweep: settings x small periods, lateness 0
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 8; s++) begin
        period_i = PW'(p);
        frame_skip_i = FW'(s);
        late_i = '0;
        do_reset();
        for (int k = 0; k < 20 * (p + 1) + 4; k++) step();
      end
    end
    // lateness sweep with period 10
    for (int s = 0; s < 4; s++) begin
      period_i = PW'(10);
      frame_skip_i = FW'(s);
      late_i = '0;
      do_reset();
      for (int k = 0; k < 400; k++) begin
        step();
        late_i = PW'((cyc * 7) % 13);
      end
    end
    // frame counter wrap with a high-bit setting
    period_i = PW'(1);
    frame_skip_i = 8'h80;
    late_i = '0;
    do_reset();
    for (int k = 0; k < 600; k++) step();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule